// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block sits between a processor that time-shares its pins and a system bus that wants stable, separate address and data. In the first clock of each bus cycle the processor places a 20-bit address on sixteen shared address/data lines and on four upper lines. Those upper lines later carry status bits. The block captures the address, together with the byte-high-enable, when the address strobe falls. It holds that address until the next accepted strobe.

The data path is a transceiver model built from plain ports. An active-low data enable turns the path on, and a direction line picks whether processor data goes out to the system side (write) or system data comes back to the processor side (read). Two byte-lane strobes are decoded from the held byte-high-enable and the held address bit 0. The strobes are active only while the data enable is asserted.

All inputs are sampled on the rising edge of `clk`. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `mux_bus_split`

## Requirements
- R1: When `ale` is sampled high and then sampled low on the next rising edge, `addr_o` shows `{ad_hi, ad_in}` as sampled in the last high cycle of `ale`, starting right after that falling-edge clock.
- R2: Once captured, `addr_o` holds its value while `ad_hi` carries status and `ad_in` carries data, until the next accepted capture.
- R3: `bhe_n_o` is captured together with the address, on the same `ale` fall, from `bhe_n` in the last high cycle of `ale`.
- R4: While `den_n` is 1, `sd_oe` and `pd_oe` are both 0.
- R5: While `den_n` is 0 and `dt_r` is 1 (write), `sd_oe` is 1, `sd_out` equals `ad_in`, and `pd_oe` is 0.
- R6: While `den_n` is 0 and `dt_r` is 0 (read), `pd_oe` is 1, `pd_out` equals `sd_in`, and `sd_oe` is 0.
- R7: While `den_n` is 0, the lane strobes follow the held `{bhe_n_o, addr_o[0]}`. The code 00 gives both lanes, 01 gives `lane_hi` only, 10 gives `lane_lo` only, and 11 gives neither. While `den_n` is 1, both strobes are 0.
- R8: A strobe fall is ignored if `den_n` was sampled 0 in the last high cycle of `ale`, which means a data phase is in progress. In that case `addr_o` and `bhe_n_o` keep their previous values.
- R9: After reset, `addr_o` is 0, `bhe_n_o` is 1, and both lane strobes and both drive enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe; the address is taken on its fall |
| ad_in | input | 16 | Shared address/data lines, processor side |
| ad_hi | input | 4 | Upper address lines that also carry status |
| bhe_n | input | 1 | Active-low byte-high-enable from the processor |
| den_n | input | 1 | Active-low data path enable |
| dt_r | input | 1 | Direction: 1 is processor to system, 0 is system to processor |
| sd_in | input | 16 | System-side data arriving for a read |
| addr_o | output | 20 | Held address |
| bhe_n_o | output | 1 | Held byte-high-enable |
| sd_out | output | 16 | Data driven onto the system side |
| sd_oe | output | 1 | Drive enable for the system side |
| pd_out | output | 16 | Data returned to the processor side |
| pd_oe | output | 1 | Drive enable for the processor side |
| lane_lo | output | 1 | Low-byte select strobe |
| lane_hi | output | 1 | High-byte select strobe |

## Verification
The hardest case to reach is a strobe pulse that arrives while a data phase is still enabled. A processor model never does this, so random bus cycles alone do not cover it. The stimulus therefore includes directed pulses with `den_n` held low across the strobe, and checks that the held address and byte-high-enable do not move. Random cycles also change the upper lines and the data lines after the capture, to show that status and data never leak into the held address.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  localparam int unsigned LO_W = 16;
  localparam int unsigned HI_W = 4;
  localparam int unsigned AW   = LO_W + HI_W;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          bhe_n;
  } cap_t;

  typedef enum logic [1:0] {
    LANE_BOTH = 2'b00,
    LANE_HIGH = 2'b01,
    LANE_LOW  = 2'b10,
    LANE_NONE = 2'b11
  } lane_code_t;
endpackage

// File: rtl/mux_addr_hold.sv
module mux_addr_hold #(
  parameter int unsigned LO_W = 16,
  parameter int unsigned HI_W = 4,
  localparam int unsigned AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_in,
  input  logic [HI_W-1:0] ad_hi,
  input  logic            bhe_n,
  input  logic            den_n,
  output logic [AW-1:0]   addr_o,
  output logic            bhe_n_o
);
  logic          ale_q, ale_d;
  logic          den_q, den_d;
  logic [AW-1:0] hold_q, hold_d;
  logic          hbhe_q, hbhe_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          bhe_q, bhe_d;
  logic          fall, take_hold, accept;

  assign fall      = ale_q & ~ale;
  assign take_hold = ale;
  assign accept    = fall & den_q;

  always_comb begin
    ale_d  = ale;
    den_d  = den_n;
    hold_d = hold_q;
    hbhe_d = hbhe_q;
    if (take_hold) begin
      hold_d = {ad_hi, ad_in};
      hbhe_d = bhe_n;
    end
    addr_d = addr_q;
    bhe_d  = bhe_q;
    if (accept) begin
      addr_d = hold_q;
      bhe_d  = hbhe_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      den_q  <= 1'b1;
      hold_q <= '0;
      hbhe_q <= 1'b1;
      addr_q <= '0;
      bhe_q  <= 1'b1;
    end else begin
      ale_q  <= ale_d;
      den_q  <= den_d;
      hold_q <= hold_d;
      hbhe_q <= hbhe_d;
      addr_q <= addr_d;
      bhe_q  <= bhe_d;
    end
  end

  assign addr_o  = addr_q;
  assign bhe_n_o = bhe_q;

  // R1: a clean fall publishes the lines seen in the last strobe-high cycle
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(ale) && $past(den_n)) |=> (addr_o == $past({ad_hi, ad_in}, 2)));

  // R3: byte-high-enable travels with the address
  p_bhe_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(ale) && $past(den_n)) |=> (bhe_n_o == $past(bhe_n, 2)));

  // R2: without a strobe fall the held address does not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ale && $past(ale)) |=> $stable(addr_o));

  // R8: a fall during an enabled data phase leaves the held values alone
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(ale) && !$past(den_n)) |=> ($stable(addr_o) && $stable(bhe_n_o)));
endmodule

// File: rtl/mux_xcvr.sv
module mux_xcvr #(
  parameter int unsigned LO_W = 16
) (
  input  logic            den_n,
  input  logic            dt_r,
  input  logic [LO_W-1:0] ad_in,
  input  logic [LO_W-1:0] sd_in,
  output logic [LO_W-1:0] sd_out,
  output logic            sd_oe,
  output logic [LO_W-1:0] pd_out,
  output logic            pd_oe
);
  logic on;
  assign on = ~den_n;

  always_comb begin
    sd_oe  = on & dt_r;
    pd_oe  = on & ~dt_r;
    sd_out = sd_oe ? ad_in : '0;
    pd_out = pd_oe ? sd_in : '0;
  end

  // R4: the two sides never drive together
  always_comb begin
    p_one_side_r4: assert (!(sd_oe && pd_oe));
  end
endmodule

// File: rtl/mux_lane_dec.sv
module mux_lane_dec
  import mux_bus_pkg::*;
(
  input  logic bhe_n_h,
  input  logic a0_h,
  input  logic den_n,
  output logic lane_lo,
  output logic lane_hi
);
  lane_code_t code;
  logic lo_raw, hi_raw;

  assign code = lane_code_t'({bhe_n_h, a0_h});

  always_comb begin
    lo_raw = 1'b0;
    hi_raw = 1'b0;
    unique case (code)
      LANE_BOTH: begin lo_raw = 1'b1; hi_raw = 1'b1; end
      LANE_HIGH: hi_raw = 1'b1;
      LANE_LOW:  lo_raw = 1'b1;
      LANE_NONE: ;
      default:   ;
    endcase
    lane_lo = lo_raw & ~den_n;
    lane_hi = hi_raw & ~den_n;
  end

  // R7: no lane strobe outside an enabled data phase
  always_comb begin
    p_lane_idle_r7: assert (!(den_n && (lane_lo || lane_hi)));
  end
endmodule

// File: rtl/mux_bus_split.sv
module mux_bus_split
  import mux_bus_pkg::*;
#(
  parameter int unsigned LO_W = mux_bus_pkg::LO_W,
  parameter int unsigned HI_W = mux_bus_pkg::HI_W,
  localparam int unsigned AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] ad_in,
  input  logic [HI_W-1:0] ad_hi,
  input  logic            bhe_n,
  input  logic            den_n,
  input  logic            dt_r,
  input  logic [LO_W-1:0] sd_in,
  output logic [AW-1:0]   addr_o,
  output logic            bhe_n_o,
  output logic [LO_W-1:0] sd_out,
  output logic            sd_oe,
  output logic [LO_W-1:0] pd_out,
  output logic            pd_oe,
  output logic            lane_lo,
  output logic            lane_hi
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  mux_addr_hold #(.LO_W(LO_W), .HI_W(HI_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ale    (ale),
    .ad_in  (ad_in),
    .ad_hi  (ad_hi),
    .bhe_n  (bhe_n),
    .den_n  (den_n),
    .addr_o (addr_o),
    .bhe_n_o(bhe_n_o)
  );

  mux_xcvr #(.LO_W(LO_W)) u_xcvr (
    .den_n (den_n),
    .dt_r  (dt_r),
    .ad_in (ad_in),
    .sd_in (sd_in),
    .sd_out(sd_out),
    .sd_oe (sd_oe),
    .pd_out(pd_out),
    .pd_oe (pd_oe)
  );

  mux_lane_dec u_lane (
    .bhe_n_h(bhe_n_o),
    .a0_h   (addr_o[0]),
    .den_n  (den_n),
    .lane_lo(lane_lo),
    .lane_hi(lane_hi)
  );

  // R9: reset leaves the byte-high-enable deasserted
  p_reset_bhe_r9: assert property (@(posedge clk)
    $rose(rst_n_s) |-> bhe_n_o);
endmodule

// File: tb/sim_mux_bus_split.sv
`timescale 1ns/1ps
module sim_mux_bus_split;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ale, bhe_n, den_n, dt_r;
  logic [15:0] ad_in, sd_in;
  logic [3:0]  ad_hi;
  logic [19:0] addr_o;
  logic        bhe_n_o, sd_oe, pd_oe, lane_lo, lane_hi;
  logic [15:0] sd_out, pd_out;

  int checks = 0;
  int fails  = 0;
  logic [19:0] exp_addr;
  logic        exp_bhe;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_split u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .ad_hi(ad_hi),
    .bhe_n(bhe_n), .den_n(den_n), .dt_r(dt_r), .sd_in(sd_in),
    .addr_o(addr_o), .bhe_n_o(bhe_n_o), .sd_out(sd_out), .sd_oe(sd_oe),
    .pd_out(pd_out), .pd_oe(pd_oe), .lane_lo(lane_lo), .lane_hi(lane_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_lo(input logic b, input logic a0, input logic dn);
    return !dn && !a0;
  endfunction
  function automatic logic exp_hi(input logic b, input logic a0, input logic dn);
    return !dn && !b;
  endfunction

  task automatic check_lanes(input string req);
    chk(req, {31'd0, lane_lo}, {31'd0, exp_lo(exp_bhe, exp_addr[0], den_n)});
    chk(req, {31'd0, lane_hi}, {31'd0, exp_hi(exp_bhe, exp_addr[0], den_n)});
  endtask

  task automatic bus_cycle(input logic [19:0] a, input logic b, input logic wr);
    logic [15:0] wd, rd;
    wd = 16'($urandom);
    rd = 16'($urandom);
    @(negedge clk);
    ale = 1'b1; ad_in = a[15:0]; ad_hi = a[19:16]; bhe_n = b; den_n = 1'b1;
    @(negedge clk);
    ale = 1'b0; ad_in = wd; ad_hi = 4'($urandom); bhe_n = 1'($urandom);
    exp_addr = a; exp_bhe = b;
    @(negedge clk);
    chk("R1", {12'd0, addr_o}, {12'd0, exp_addr});
    chk("R3", {31'd0, bhe_n_o}, {31'd0, exp_bhe});
    den_n = 1'b0; dt_r = wr; sd_in = rd; ad_hi = 4'($urandom);
    #1;
    if (wr) begin
      chk("R5", {15'd0, sd_oe, pd_oe}, {15'd0, 2'b10});
      chk("R5", {16'd0, sd_out}, {16'd0, wd});
    end else begin
      chk("R6", {15'd0, sd_oe, pd_oe}, {15'd0, 2'b01});
      chk("R6", {16'd0, pd_out}, {16'd0, rd});
    end
    check_lanes("R7");
    @(negedge clk);
    ad_hi = 4'($urandom); ad_in = 16'($urandom);
    @(negedge clk);
    chk("R2", {12'd0, addr_o}, {12'd0, exp_addr});
    den_n = 1'b1;
    #1;
    chk("R4", {30'd0, sd_oe, pd_oe}, 32'd0);
    check_lanes("R7");
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ale = 1'b0; ad_in = '0; ad_hi = '0; bhe_n = 1'b1;
    den_n = 1'b1; dt_r = 1'b0; sd_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", {12'd0, addr_o}, 32'd0);
    chk("R9", {31'd0, bhe_n_o}, 32'd1);
    chk("R9", {28'd0, lane_lo, lane_hi, sd_oe, pd_oe}, 32'd0);

    // directed: all four lane codes, both directions
    bus_cycle(20'hABCD0, 1'b0, 1'b1);
    bus_cycle(20'h12341, 1'b0, 1'b0);
    bus_cycle(20'hFFFF0, 1'b1, 1'b1);
    bus_cycle(20'h00001, 1'b1, 1'b0);

    // directed R8: strobe pulse during an enabled data phase
    @(negedge clk);
    den_n = 1'b0; dt_r = 1'b1; ale = 1'b1; ad_in = 16'h5A5A; ad_hi = 4'h9; bhe_n = 1'b0;
    @(negedge clk);
    ale = 1'b0;
    @(negedge clk);
    chk("R8", {12'd0, addr_o}, {12'd0, exp_addr});
    chk("R8", {31'd0, bhe_n_o}, {31'd0, exp_bhe});
    check_lanes("R7");
    den_n = 1'b1;

    for (int i = 0; i < 40; i++)
      bus_cycle(20'($urandom), 1'($urandom), 1'($urandom));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule